// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the housekeeping side of an asynchronous DRAM whose refresh row counter sits inside the memory. After reset it stays silent for a programmable power-up pause. It then runs a warm-up burst of refresh cycles. From then on it schedules one refresh per programmable interval, which spreads 1024 row refreshes evenly over the retention period. Every refresh uses /CAS-before-/RAS ordering, so no row address is ever driven. The memory only needs the strobes.

The sequencer shares the DRAM pins with an access controller through a request/grant handshake. When a refresh is due it raises `rfsh_req` and holds it, with the strobes idle, until `rfsh_grant` is seen. A long page burst can therefore delay refreshes. The sequencer counts each interval that expires while it waits, up to a small limit, and runs all the owed refreshes back to back once it is granted. While it owns the pins, `bus_own` is high and the block drives `/RAS`, `/CAS` and a high `/WE`. `mem_ready` rises once the warm-up burst has finished and tells the access controller that normal traffic may begin.

Handshake rules: `rfsh_grant` is looked at only while `rfsh_req` is high and `bus_own` is low. Ownership starts on the clock after the grant is seen. The block keeps the pins, with `rfsh_req` still high, until the precharge of its last owed refresh is over. The pins return to the access controller on the clock where `rfsh_req` falls. The grant may then be withdrawn.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ras_n`=1, `cas_n`=1, `rfsh_req`=0, `bus_own`=0 and `mem_ready`=0.
- R2: After reset is released, `rfsh_req` stays low and both strobes stay high for PAUSE_CYC cycles. `rfsh_req` rises within two cycles after that.
- R3: Exactly WARMUP_N refresh cycles run after the pause, all under one unbroken request. `mem_ready` rises after the last of them and then stays high until the next reset.
- R4: In every refresh, `cas_n` falls CAS_LEAD cycles before `ras_n` falls. It stays low for CAS_HOLD cycles from the fall of `ras_n`, and it is high again before `ras_n` rises.
- R5: `ras_n` stays low for exactly RAS_LOW cycles per refresh. Between refreshes of one burst, both strobes are high together for at least PRECH cycles.
- R6: `we_n` is high on every cycle in which the block owns the pins.
- R7: Once `mem_ready` is high, a refresh becomes due every INTERVAL_CYC cycles. If the grant is held high, consecutive refreshes start exactly INTERVAL_CYC cycles apart.
- R8: A due refresh raises `rfsh_req`, which stays high while no grant is seen. Until then `bus_own` is low and both strobes stay high. Ownership begins only on the cycle after a grant.
- R9: Intervals that expire while the request waits are counted, up to DEBT_MAX. On grant, that many refreshes run back to back in one ownership period. Intervals beyond DEBT_MAX are dropped.
- R10: After the last owed refresh, `rfsh_req` and `bus_own` fall together and both strobes are left high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfsh_grant | input | 1 | Grant from the access controller |
| rfsh_req | output | 1 | Refresh request; high from due until the pins are released |
| bus_own | output | 1 | High while the sequencer drives the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| mem_ready | output | 1 | High once the power-up sequence is finished |

## Verification
The bound checker watches the strobe ordering of every refresh on every cycle. It checks that `/CAS` is low before `/RAS` falls and high again before `/RAS` rises, that the `/RAS` low width is exact, and that precharge lasts long enough. It also checks that the strobes stay idle whenever the pins are not owned, that a waiting request is held, that ownership follows a grant, and that `mem_ready` never falls. Some properties only the bench scenarios can show: the length of the power-up pause, the number of warm-up refreshes, the exact interval spacing, and how many refreshes a withheld grant accumulates and later releases, including saturation at the debt limit. A reset in the middle of a refresh, followed by a fresh power-up sequence, is also covered only there.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,
    ST_IDLE  = 3'd1,
    ST_REQ   = 3'd2,
    ST_CAS   = 3'd3,
    ST_RAS   = 3'd4,
    ST_PRE   = 3'd5
  } rfsh_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
// Power-up pause counter and free-running refresh interval ticker.
module rfsh_timer #(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pause_done,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] INT_LAST   = IW'(INTERVAL_CYC - 1);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] int_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_cnt  <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      pause_cnt <= pause_cnt + 1'b1;
      if (pause_cnt == PAUSE_LAST) pause_done <= 1'b1;
    end
  end

  // interval ticker only runs once the memory is released for use
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      int_cnt <= '0;
    end else if (int_cnt == INT_LAST) begin
      int_cnt <= '0;
    end else begin
      int_cnt <= int_cnt + 1'b1;
    end
  end

  assign tick = run && (int_cnt == INT_LAST);

endmodule

// File: rtl/rfsh_ledger.sv
// Tracks warm-up refreshes still owed and periodic refreshes overdue.
module rfsh_ledger #(
  parameter int WARMUP_N = 8,
  parameter int DEBT_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  output logic pending,
  output logic ready
);
  localparam int WW = $clog2(WARMUP_N + 1);

  logic [WW-1:0] warm_left;
  logic          warm_busy;
  logic          debt_nz;
  logic          pay;

  assign warm_busy = (warm_left != '0);
  assign pay       = done && !warm_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warm_left <= WW'(WARMUP_N);
    end else if (done && warm_busy) begin
      warm_left <= warm_left - 1'b1;
    end
  end

  generate
    if (DEBT_MAX == 1) begin : g_debt_bit
      logic owed;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          owed <= 1'b0;
        end else if (tick) begin
          owed <= 1'b1;
        end else if (pay) begin
          owed <= 1'b0;
        end
      end
      assign debt_nz = owed;
    end else begin : g_debt_cnt
      localparam int DW = $clog2(DEBT_MAX + 1);
      localparam logic [DW-1:0] DCAP = DW'(DEBT_MAX);
      logic [DW-1:0] owed;
      logic          dec;
      logic          inc;
      assign dec = pay && (owed != '0);
      assign inc = tick && ((owed != DCAP) || dec);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          owed <= '0;
        end else if (inc && !dec) begin
          owed <= owed + 1'b1;
        end else if (dec && !inc) begin
          owed <= owed - 1'b1;
        end
      end
      assign debt_nz = (owed != '0);
    end
  endgenerate

  assign pending = warm_busy || debt_nz;
  assign ready   = !warm_busy;

endmodule

// File: rtl/rfsh_wave.sv
// Handshake and /CAS-before-/RAS strobe generator.
module rfsh_wave
  import rfsh_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int RAS_LOW  = 9,
  parameter int CAS_HOLD = 2,
  parameter int PRECH    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic pending,
  input  logic gnt,
  output logic req,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic done
);
  localparam int PMAX = max2(max2(CAS_LEAD, RAS_LOW), max2(CAS_HOLD, PRECH));
  localparam int CW   = $clog2(PMAX + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(CAS_LEAD - 1);
  localparam logic [CW-1:0] RAS_LAST  = CW'(RAS_LOW - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRECH - 1);
  localparam logic [CW-1:0] HOLD_END  = CW'(CAS_HOLD);

  rfsh_st_e      st_q, st_d;
  logic [CW-1:0] ph_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PAUSE: if (pause_done) st_d = pending ? ST_REQ : ST_IDLE;
      ST_IDLE:  if (pending) st_d = ST_REQ;
      ST_REQ:   if (gnt) st_d = ST_CAS;
      ST_CAS:   if (ph_q == LEAD_LAST) st_d = ST_RAS;
      ST_RAS:   if (ph_q == RAS_LAST) st_d = ST_PRE;
      ST_PRE:   if (ph_q == PRE_LAST) st_d = pending ? ST_CAS : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_PAUSE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= (st_d != st_q) ? '0 : ph_q + 1'b1;
    end
  end

  assign own   = (st_q == ST_CAS) || (st_q == ST_RAS) || (st_q == ST_PRE);
  assign req   = own || (st_q == ST_REQ);
  assign ras_n = (st_q != ST_RAS);
  assign cas_n = !((st_q == ST_CAS) || ((st_q == ST_RAS) && (ph_q < HOLD_END)));
  assign done  = (st_q == ST_RAS) && (ph_q == RAS_LAST);

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq #(
  parameter int PAUSE_CYC    = 25000,
  parameter int WARMUP_N     = 8,
  parameter int INTERVAL_CYC = 1950,
  parameter int DEBT_MAX     = 4,
  parameter int CAS_LEAD     = 1,
  parameter int RAS_LOW      = 9,
  parameter int CAS_HOLD     = 2,
  parameter int PRECH        = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_grant,
  output logic rfsh_req,
  output logic bus_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic mem_ready
);
  logic pause_done;
  logic tick;
  logic pending;
  logic done;

  rfsh_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (mem_ready),
    .pause_done(pause_done),
    .tick      (tick)
  );

  rfsh_ledger #(
    .WARMUP_N(WARMUP_N),
    .DEBT_MAX(DEBT_MAX)
  ) u_ledger (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .done   (done),
    .pending(pending),
    .ready  (mem_ready)
  );

  rfsh_wave #(
    .CAS_LEAD(CAS_LEAD),
    .RAS_LOW (RAS_LOW),
    .CAS_HOLD(CAS_HOLD),
    .PRECH   (PRECH)
  ) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause_done(pause_done),
    .pending   (pending),
    .gnt       (rfsh_grant),
    .req       (rfsh_req),
    .own       (bus_own),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .done      (done)
  );

  // refresh never writes; the access controller supplies /WE for its own cycles
  assign we_n = 1'b1;

endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int RAS_LOW = 9,
  parameter int PRECH   = 7
) (
  input logic clk,
  input logic rst_n,
  input logic rfsh_grant,
  input logic rfsh_req,
  input logic bus_own,
  input logic ras_n,
  input logic cas_n,
  input logic mem_ready
);
  localparam int RLW = $clog2(RAS_LOW + 2);
  localparam int RHW = $clog2(PRECH + 1);
  localparam logic [RLW-1:0] RL_CAP = RLW'(RAS_LOW + 1);
  localparam logic [RHW-1:0] RH_CAP = RHW'(PRECH);

  logic [RLW-1:0] low_run;
  logic [RHW-1:0] high_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= RH_CAP;
    end else if (!ras_n) begin
      high_run <= '0;
      if (low_run != RL_CAP) low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
      if (high_run != RH_CAP) high_run <= high_run + 1'b1;
    end
  end

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  a_r4_cas_up_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run == RLW'(RAS_LOW)));

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_run == RH_CAP));

  a_r8_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n));

  a_r8_own_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> rfsh_req);

  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !bus_own && !rfsh_grant) |=> rfsh_req);

  a_r8_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(rfsh_grant));

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);

endmodule

bind dram_rfsh_seq rfsh_seq_chk #(
  .RAS_LOW(RAS_LOW),
  .PRECH  (PRECH)
) u_rfsh_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rfsh_grant(rfsh_grant),
  .rfsh_req  (rfsh_req),
  .bus_own   (bus_own),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .mem_ready (mem_ready)
);

// File: tb/dram_rfsh_seq_bench.sv
`timescale 1ns/1ps
module dram_rfsh_seq_bench;
  localparam int PAUSE = 300;
  localparam int WARM  = 8;
  localparam int IVL   = 200;
  localparam int DMAX  = 4;
  localparam int LEAD  = 1;
  localparam int RLOW  = 6;
  localparam int HOLD  = 2;
  localparam int PRE   = 4;

  // stimulus: intervals to withhold the grant; expected: refreshes in the burst (R9)
  localparam int NV = 5;
  localparam int VEC_K [NV] = '{1, 2, 3, 4, 6};
  localparam int VEC_E [NV] = '{1, 2, 3, 4, 4};

  logic clk = 1'b0;
  logic rst_n;
  logic rfsh_grant;
  logic rfsh_req, bus_own, ras_n, cas_n, we_n, mem_ready;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dram_rfsh_seq #(
    .PAUSE_CYC(PAUSE), .WARMUP_N(WARM), .INTERVAL_CYC(IVL), .DEBT_MAX(DMAX),
    .CAS_LEAD(LEAD), .RAS_LOW(RLOW), .CAS_HOLD(HOLD), .PRECH(PRE)
  ) u_dram_rfsh_seq (
    .clk(clk), .rst_n(rst_n), .rfsh_grant(rfsh_grant), .rfsh_req(rfsh_req),
    .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .mem_ready(mem_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe monitor, sampled at the falling edge
  int  cyc = 0;
  int  nstart = 0;
  int  ngap = 0;
  bit  gap_on = 1'b0;
  bit  have_start;
  int  last_start;
  int  lead_c, hold_c, low_c, pre_c;
  bit  pre_ok;
  logic prev_ras, prev_cas;

  always @(negedge clk) begin
    cyc++;
    if (!gap_on) have_start = 1'b0;
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1;
      lead_c = 0; hold_c = 0; low_c = 0; pre_c = 0; pre_ok = 1'b0;
    end else begin
      if (prev_cas && !cas_n && ras_n) begin
        if (pre_ok) chk(pre_c >= PRE, "R5 precharge cycles", pre_c, PRE);
        if (gap_on && have_start) begin
          chk(cyc - last_start == IVL, "R7 refresh spacing", cyc - last_start, IVL);
          ngap++;
        end
        last_start = cyc; have_start = 1'b1;
        nstart++; lead_c = 1; pre_ok = 1'b0;
      end else if (!cas_n && ras_n) begin
        lead_c++;
      end
      if (prev_ras && !ras_n) begin
        chk(lead_c == LEAD, "R4 cas lead", lead_c, LEAD);
        chk(we_n == 1'b1, "R6 we_n during refresh", we_n, 1);
        low_c = 1; hold_c = cas_n ? 0 : 1;
      end else if (!ras_n) begin
        low_c++;
        if (!cas_n) hold_c++;
      end
      if (!prev_ras && ras_n) begin
        chk(low_c == RLOW, "R5 ras low width", low_c, RLOW);
        chk(hold_c == HOLD, "R4 cas hold", hold_c, HOLD);
        pre_c = cas_n ? 1 : 0; pre_ok = 1'b1;
      end else if (ras_n && cas_n && pre_ok) begin
        pre_c++;
      end
      if (!bus_own) pre_ok = 1'b0;
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  task automatic check_reset_state(input string tag);
    chk(ras_n == 1'b1, {tag, " ras_n"}, ras_n, 1);
    chk(cas_n == 1'b1, {tag, " cas_n"}, cas_n, 1);
    chk(rfsh_req == 1'b0, {tag, " rfsh_req"}, rfsh_req, 0);
    chk(bus_own == 1'b0, {tag, " bus_own"}, bus_own, 0);
    chk(mem_ready == 1'b0, {tag, " mem_ready"}, mem_ready, 0);
  endtask

  task automatic check_pause(input string tag);
    int  t = 0;
    bit  quiet = 1'b1;
    while (!rfsh_req && t < PAUSE + 50) begin
      @(negedge clk);
      t++;
      if (!ras_n || !cas_n) quiet = 1'b0;
    end
    chk(t >= PAUSE && t <= PAUSE + 2, {tag, " pause length"}, t, PAUSE + 1);
    chk(quiet, {tag, " strobes quiet in pause"}, quiet, 1);
  endtask

  initial begin
    int s0, drops, t, w;
    bit held;
    rst_n = 1'b0;
    rfsh_grant = 1'b0;
    repeat (4) @(negedge clk);
    check_reset_state("R1");

    // power-up pause and warm-up, grant always available
    rfsh_grant = 1'b1;
    rst_n = 1'b1;
    check_pause("R2");
    s0 = nstart; drops = 0; t = 0;
    while (!mem_ready && t < 1000) begin
      @(negedge clk);
      t++;
      if (!rfsh_req) drops++;
    end
    chk(nstart - s0 == WARM, "R3 warm-up refresh count", nstart - s0, WARM);
    chk(drops == 0, "R3 request unbroken in warm-up", drops, 0);
    t = 0;
    while (rfsh_req && t < 100) begin @(negedge clk); t++; end
    chk(!rfsh_req && !bus_own, "R10 release after warm-up", rfsh_req, 0);

    // steady periodic refresh with the grant held
    gap_on = 1'b1;
    repeat (4 * IVL + 60) @(negedge clk);
    gap_on = 1'b0;
    chk(ngap >= 3, "R7 spacing samples", ngap, 3);

    // withheld grant, debt accumulation and burst release
    for (int i = 0; i < NV; i++) begin
      t = 0;
      while (rfsh_req && t < IVL) begin @(negedge clk); t++; end
      rfsh_grant = 1'b0;
      t = 0;
      while (!rfsh_req && t < 2 * IVL) begin @(negedge clk); t++; end
      held = 1'b1;
      w = VEC_K[i] * IVL - IVL / 2;
      repeat (w) begin
        @(negedge clk);
        if (!rfsh_req || bus_own || !ras_n || !cas_n) held = 1'b0;
      end
      chk(held, "R8 request held, pins idle without grant", held, 1);
      rfsh_grant = 1'b1;
      s0 = nstart; t = 0;
      @(negedge clk);
      while (rfsh_req && t < 200) begin @(negedge clk); t++; end
      chk(nstart - s0 == VEC_E[i], "R9 burst length", nstart - s0, VEC_E[i]);
      chk(!bus_own && ras_n && cas_n, "R10 pins released", bus_own, 0);
    end
    chk(mem_ready == 1'b1, "R3 ready stays high", mem_ready, 1);

    // reset in the middle of a refresh, then a fresh power-up
    t = 0;
    while (ras_n && t < 2 * IVL) begin @(negedge clk); t++; end
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1 mid-refresh");
    @(negedge clk);
    rst_n = 1'b1;
    check_pause("R2 after re-reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule